// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits beside a small microcontroller core and decides which of its clocks may run. Software writes a power-control register over a simple register bus. One bit of that register requests idle, another requests power-down, and two further bits are general-purpose flags. A fifth bit marks an idle request as having been made on behalf of an analog-to-digital converter.

From the register state the block drives three registered clock-enable outputs: one for the CPU, one for the peripherals and one for the oscillator. In idle only the CPU clock stops. In power-down the oscillator stops, and every clock stops with it. An enabled interrupt request ends either state. A conversion-complete event ends an idle that was entered with the converter bit set. The asynchronous reset input clears every mode bit at once, without waiting for a clock edge. A reset sequencer output then stays high for a fixed number of cycles after reset is released, and a constant output gives the reset vector address.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: The register reads back as bit 0 idle, bit 1 power-down, bit 2 flag 0, bit 3 flag 1, bit 4 converter-idle qualifier, with bits 7:5 reading 0. A write in run mode takes effect at the next rising edge.
- R2: A write with bit 0 set and bit 1 clear enters idle at that edge. The mode output becomes 01, the CPU enable goes to 0, and the peripheral and oscillator enables stay at 1.
- R3: A write with bit 1 set enters power-down at that edge. The mode output becomes 10 and all three enables go to 0.
- R4: A write with bits 0 and 1 both set enters power-down only, and bit 0 reads 0. After the wake-up the mode is 00 (run), not idle.
- R5: An interrupt request present at a rising edge while idle clears the idle bit and the qualifier bit. The mode returns to 00 with all enables at 1.
- R6: An interrupt request present at a rising edge while in power-down clears the power-down bit and returns the mode to 00 with all enables at 1.
- R7: A conversion-complete event ends idle only when the qualifier bit (bit 4) was set by the same write that entered idle. Without the qualifier it has no effect, and it has no effect in run or power-down. The qualifier bit only stores a 1 when the same write enters idle.
- R8: The reset input is active high. While it is high, the register reads 0, the mode is 00 and all three enables are 1. This holds from the moment reset is asserted, before any clock edge.
- R9: The hardware never changes flag bits 2 and 3. They hold their value through idle, power-down and each wake-up.
- R10: The reset sequencer output is 1 during reset and falls at the RST_CYCLES-th rising edge after reset is released (default 16). The vector output always reads RESET_VEC (default 0x0000).
- R11: A register write while the mode is idle or power-down is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Asynchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_req | input | 1 | Enabled interrupt request (wake source) |
| adc_done | input | 1 | Converter conversion-complete event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | Current mode: 00 run, 01 idle, 10 power-down |
| rst_seq | output | 1 | Reset sequencer active |
| boot_vec | output | 16 | Reset vector address |

## Verification
The bench writes idle and power-down together and checks that the result is power-down only and that the wake-up lands in run. A design that let idle win, or that dropped back into idle on wake-up, would show mode 01 there. It sends conversion-complete events both with and without the qualifier bit set, and during power-down. A design that treated the event as a general wake source would leave idle or power-down too early. It raises reset in the middle of idle and samples before the next clock edge, which catches a reset that only takes effect synchronously. It also writes the register while idle or power-down and checks that the write is ignored and that the flag bits stay unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int unsigned PCON_BITS = 5;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_PD   = 2'b10
    } lpm_mode_e;

    // Field order is the register bit map, bit 4 down to bit 0.
    typedef struct packed {
        logic adc;
        logic gf1;
        logic gf0;
        logic pd;
        logic idle;
    } pcon_t;

    typedef struct packed {
        logic      cpu;
        logic      per;
        logic      osc;
        lpm_mode_e mode;
    } clk_en_t;

endpackage

// File: rtl/lpm_pcon_reg.sv
module lpm_pcon_reg
    import lpm_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             irq,
    input  logic             adc_done,
    output pcon_t            pcon_q,
    output pcon_t            pcon_d
);

    pcon_t cur_q;
    pcon_t nxt_d;
    logic  run_mode;
    logic  idle_wake;
    logic  pd_wake;
    logic  both_req;

    always_comb begin
        nxt_d     = cur_q;
        run_mode  = !cur_q.idle && !cur_q.pd;
        idle_wake = cur_q.idle && (irq || (cur_q.adc && adc_done));
        pd_wake   = cur_q.pd && irq;
        both_req  = wdata[0] && wdata[1];
        if (idle_wake) begin
            nxt_d.idle = 1'b0;
            nxt_d.adc  = 1'b0;
        end else if (pd_wake) begin
            nxt_d.pd   = 1'b0;
            nxt_d.idle = 1'b0;
        end else if (run_mode && we) begin
            // power-down takes precedence over a simultaneous idle request
            nxt_d.idle = wdata[0] && !both_req;
            nxt_d.pd   = wdata[1];
            nxt_d.gf0  = wdata[2];
            nxt_d.gf1  = wdata[3];
            nxt_d.adc  = wdata[4] && wdata[0] && !both_req;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pcon_q = cur_q;
    assign pcon_d = nxt_d;

endmodule

// File: rtl/lpm_enable_gen.sv
module lpm_enable_gen
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pcon_t     pcon_d,
    output logic      cpu_clk_en,
    output logic      per_clk_en,
    output logic      osc_en,
    output lpm_mode_e mode
);

    clk_en_t en_d;
    clk_en_t en_q;

    always_comb begin
        en_d.cpu  = !pcon_d.idle && !pcon_d.pd;
        en_d.per  = !pcon_d.pd;
        en_d.osc  = !pcon_d.pd;
        if (pcon_d.pd) begin
            en_d.mode = MODE_PD;
        end else if (pcon_d.idle) begin
            en_d.mode = MODE_IDLE;
        end else begin
            en_d.mode = MODE_RUN;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            en_q <= '{cpu: 1'b1, per: 1'b1, osc: 1'b1, mode: MODE_RUN};
        end else begin
            en_q <= en_d;
        end
    end

    assign cpu_clk_en = en_q.cpu;
    assign per_clk_en = en_q.per;
    assign osc_en     = en_q.osc;
    assign mode       = en_q.mode;

endmodule

// File: rtl/lpm_rst_seq.sv
module lpm_rst_seq #(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    output logic rst_seq
);

    generate
        if (RST_CYCLES == 0) begin : g_none
            assign rst_seq = rst;
        end else begin : g_cnt
            localparam int unsigned CW = $clog2(RST_CYCLES + 1);
            localparam logic [CW-1:0] START = CW'(RST_CYCLES);

            logic [CW-1:0] cnt_d;
            logic [CW-1:0] cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end

            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    cnt_q <= START;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign rst_seq = (cnt_q != '0);
        end
    endgenerate

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int unsigned REG_W      = 8,
    parameter int unsigned RST_CYCLES = 16,
    parameter int unsigned VEC_W      = 16,
    parameter logic [15:0] RESET_VEC  = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             irq_req,
    input  logic             adc_done,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic [1:0]       mode,
    output logic             rst_seq,
    output logic [VEC_W-1:0] boot_vec
);

    localparam int unsigned PAD_W = REG_W - PCON_BITS;

    pcon_t     pcon_q;
    pcon_t     pcon_d;
    lpm_mode_e mode_e;

    lpm_pcon_reg #(.REG_W(REG_W)) u_pcon (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .irq      (irq_req),
        .adc_done (adc_done),
        .pcon_q   (pcon_q),
        .pcon_d   (pcon_d)
    );

    lpm_enable_gen u_en (
        .clk        (clk),
        .rst        (rst),
        .pcon_d     (pcon_d),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_en     (osc_en),
        .mode       (mode_e)
    );

    lpm_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .rst_seq (rst_seq)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign reg_rdata = {{PAD_W{1'b0}}, pcon_q};
        end else begin : g_nopad
            assign reg_rdata = pcon_q;
        end
    endgenerate

    assign mode     = mode_e;
    assign boot_vec = VEC_W'(RESET_VEC);

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       irq_req,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic [1:0] mode,
    input logic       rst_seq
);

    // R4
    property pd_excludes_idle_p;
        @(posedge clk) disable iff (rst) !(reg_rdata[0] && reg_rdata[1]);
    endproperty
    pd_excludes_idle_chk: assert property (pd_excludes_idle_p);

    // R5
    property idle_irq_wake_p;
        @(posedge clk) disable iff (rst) (mode == 2'b01 && irq_req) |=> (mode == 2'b00 && cpu_clk_en);
    endproperty
    idle_irq_wake_chk: assert property (idle_irq_wake_p);

    // R6
    property pd_irq_wake_p;
        @(posedge clk) disable iff (rst) (mode == 2'b10 && irq_req) |=> (mode == 2'b00 && osc_en);
    endproperty
    pd_irq_wake_chk: assert property (pd_irq_wake_p);

    // R9
    property flags_held_p;
        @(posedge clk) disable iff (rst) !reg_we |=> $stable(reg_rdata[3:2]);
    endproperty
    flags_held_chk: assert property (flags_held_p);

    // R3
    property osc_off_all_off_p;
        @(posedge clk) disable iff (rst) !osc_en |-> (!per_clk_en && !cpu_clk_en && mode == 2'b10);
    endproperty
    osc_off_all_off_chk: assert property (osc_off_all_off_p);

    // R2
    property idle_enables_p;
        @(posedge clk) disable iff (rst) (mode == 2'b01) |-> (!cpu_clk_en && per_clk_en && osc_en);
    endproperty
    idle_enables_chk: assert property (idle_enables_p);

    // R8 and R10
    always @(negedge clk) begin
        if (rst) begin
            reset_state_chk: assert (cpu_clk_en && per_clk_en && osc_en && mode == 2'b00
                                     && reg_rdata == 8'h00 && rst_seq);
        end
    end

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .irq_req    (irq_req),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .mode       (mode),
    .rst_seq    (rst_seq)
);

// File: tb/lpm_clk_ctrl_test.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_test;

    localparam int RSTC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_req = 1'b0;
    logic        adc_done = 1'b0;
    logic        cpu_clk_en, per_clk_en, osc_en, rst_seq;
    logic [1:0]  mode;
    logic [15:0] boot_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic m_idle, m_pd, m_gf0, m_gf1, m_adc;

    always #2.5 clk = ~clk;

    lpm_clk_ctrl #(.RST_CYCLES(RSTC)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .adc_done(adc_done),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .mode(mode), .rst_seq(rst_seq), .boot_vec(boot_vec)
    );

    function automatic logic [7:0] exp_rdata();
        return {3'b000, m_adc, m_gf1, m_gf0, m_pd, m_idle};
    endfunction

    function automatic logic [1:0] exp_mode();
        return m_pd ? 2'b10 : (m_idle ? 2'b01 : 2'b00);
    endfunction

    function automatic logic [2:0] exp_en();
        return {!m_idle && !m_pd, !m_pd, !m_pd};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, {19'd0, reg_rdata, mode, cpu_clk_en, per_clk_en, osc_en},
                   {19'd0, exp_rdata(), exp_mode(), exp_en()});
    endtask

    task automatic model_reset();
        {m_idle, m_pd, m_gf0, m_gf1, m_adc} = '0;
    endtask

    // Expected register update at one rising edge, from the requirements.
    task automatic model_edge(input logic we, input logic [7:0] d, input logic i, input logic a);
        if (m_idle && (i || (m_adc && a))) begin
            m_idle = 0; m_adc = 0;                       // R5, R7
        end else if (m_pd && i) begin
            m_pd = 0;                                    // R6
        end else if (!m_idle && !m_pd && we) begin       // R1, R11
            m_pd   = d[1];
            m_idle = d[0] && !d[1];                      // R4
            m_adc  = d[4] && d[0] && !d[1];
            m_gf0  = d[2];
            m_gf1  = d[3];
        end
    endtask

    // Called at a falling edge; checks at the next falling edge.
    task automatic step(input logic we, input logic [7:0] d, input logic i,
                        input logic a, input string tag);
        reg_we = we; reg_wdata = d; irq_req = i; adc_done = a;
        @(posedge clk);
        model_edge(we, d, i, a);
        @(negedge clk);
        reg_we = 0; irq_req = 0; adc_done = 0;
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #0.5 rst = 1;
        model_reset();
        @(negedge clk);
        check_all("R8 reset state");
        check("R10 seq during reset", {31'd0, rst_seq}, 32'd1);
        rst = 0;
        for (int k = 1; k <= RSTC + 2; k++) begin
            @(negedge clk);
            if (!rst_seq) begin
                check("R10 seq length", k, RSTC);
                break;
            end
            if (k == RSTC + 2) check("R10 seq length", k, RSTC);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        model_reset();
        #1 rst = 1;
        do_reset();
        check("R10 vector", {16'd0, boot_vec}, 32'h0);

        // R1: plain flag write in run
        step(1, 8'hEC, 0, 0, "R1 flag write");
        // R2: idle entry keeps flags (R9)
        step(1, 8'h0D, 0, 0, "R2 idle entry");
        // R11: write in idle ignored
        step(1, 8'h02, 0, 0, "R11 write in idle");
        // R7: conversion complete without qualifier ignored
        step(0, 8'h00, 0, 1, "R7 adc ignored");
        // R5: interrupt wakes idle
        step(0, 8'h00, 1, 0, "R5 irq wakes idle");
        check("R9 flags kept", {30'd0, reg_rdata[3:2]}, 32'd3);
        // R7: qualified idle ends on conversion complete
        step(1, 8'h11, 0, 0, "R7 adc idle entry");
        step(0, 8'h00, 0, 1, "R7 adc wakes idle");
        // R4: both bits -> power-down only
        step(1, 8'h07, 0, 0, "R4 both set");
        step(0, 8'h00, 0, 1, "R7 adc ignored in pd");
        step(1, 8'h00, 0, 0, "R11 write in pd");
        step(0, 8'h00, 1, 0, "R4 wake to run");
        check("R9 flags after pd", {30'd0, reg_rdata[3:2]}, 32'd1);
        // R3: power-down and R6 wake
        step(1, 8'h02, 0, 0, "R3 pd entry");
        step(0, 8'h00, 1, 0, "R6 irq wakes pd");

        // R8: asynchronous reset in the middle of idle
        step(1, 8'h01, 0, 0, "R2 idle before reset");
        #0.5 rst = 1;
        #0.5;
        model_reset();
        check_all("R8 async reset");
        @(negedge clk);
        rst = 0;
        repeat (RSTC + 1) @(negedge clk);

        for (int n = 0; n < 4000; n++) begin
            logic we, i, a;
            logic [7:0] d;
            string tag;
            we = ($urandom % 3) == 0;
            d  = 8'($urandom);
            i  = ($urandom % 8) == 0;
            a  = ($urandom % 4) == 0;
            step(we, d, i, a, "rand");
            tag = m_pd ? "R3 random" : (m_idle ? "R2 random" : "R1 random");
            check_all(tag);
        end

        do_reset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule